// File: doc/BRIEF.md
# Open-Collector Serial Transmit Shifter

This block turns a parallel word into a serial stream on one shared, wired line. A load strobe, sampled on a rising clock edge while the block is idle, captures the word on `par_data`. From the next clock period on, the block presents one bit per clock, most significant bit first. A one pulls the line low. A zero leaves the line floating, so an external pull-up reads it as high. Between transfers the line is always released, so other drivers may share it.

A `busy` flag is high for exactly `WIDTH` clock periods per word. During that time the block ignores any further load strobe. The block only drives the line and never reads it back. The word on `par_data` must be stable at least one clock period before the strobe. An active-low reset acts at once and stops any transfer in progress. The reset is assumed to be released in step with the clock.

Top module: `oc_tx_top`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `busy` is 0 and `tx_line` is high impedance.
- R2: A `load` sampled high on a rising edge while `busy` is 0 captures `par_data`, and `busy` reads 1 in the period that follows that edge.
- R3: In the k-th clock period after the capturing edge (k = 0 .. WIDTH-1), the line carries bit WIDTH-1-k of the captured word, so the MSB goes first.
- R4: While `busy` is 1, a current bit of 1 drives `tx_line` to 0, and a current bit of 0 leaves it high impedance.
- R5: `busy` stays 1 for exactly WIDTH clock periods per accepted word, then returns to 0.
- R6: While `busy` is 0, `tx_line` is high impedance, whatever `par_data` holds.
- R7: A `load` strobe sampled while `busy` is 1, including in the last bit period, is ignored. The word in flight and its length are unchanged.
- R8: Changes on `par_data` after the capturing edge do not alter the bits being sent.
- R9: Pulling `rst_n` low during a transfer makes `busy` 0 and releases `tx_line` at once, without waiting for a clock edge.
- R10: A `load` strobe in the first period in which `busy` is 0 again is accepted, giving back-to-back words with one idle period between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load | input | 1 | Capture strobe for the parallel word |
| par_data | input | WIDTH | Parallel word to send |
| busy | output | 1 | High while a word is being shifted out |
| tx_line | output | 1 | Open-collector serial output: 0 or high impedance |

## Verification
The assertions assume that `par_data` has settled before any edge that samples `load` high, and that `rst_n` changes away from the rising clock edge. The bench changes every input on the falling clock edge. It sets up each word one period before its strobe, or during the previous transfer when words are sent back to back. The one exception is reset, which is pulled low a quarter period after a falling edge to check that it acts at once, and is released on a falling edge. The bench models the wired line with a pull-up, so a released line reads as 1.

// File: rtl/oc_tx_pkg.sv
package oc_tx_pkg;
  // Level placed on the shared line when the block pulls it.
  localparam logic LINE_PULL = 1'b0;

  // Counter width needed to index the bits of a word.
  function automatic int unsigned idx_width(input int unsigned w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/oc_tx_ctrl.sv
module oc_tx_ctrl
  import oc_tx_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active,
  output logic take,
  output logic shift_en
);
  localparam int unsigned CW = idx_width(WIDTH);
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  assign take     = load & ~act_q;
  assign shift_en = act_q & (cnt_q != '0);
  assign active   = act_q;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (take) begin
      act_d = 1'b1;
      cnt_d = LAST_IDX;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !act_q) |=> (act_q && cnt_q == LAST_IDX));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q != '0) |=> (act_q && cnt_q == $past(cnt_q) - 1'b1));

  // R5
  end_of_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q == '0 && !load) |=> !act_q);

  // R7
  load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && load && cnt_q == '0) |=> !act_q);
endmodule

// File: rtl/oc_tx_sreg.sv
module oc_tx_sreg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] din,
  output logic             msb
);
  logic [WIDTH-1:0] word_q, word_d;

  generate
    if (WIDTH > 1) begin : g_multi
      always_comb begin
        word_d = word_q;
        if (take)          word_d = din;
        else if (shift_en) word_d = {word_q[WIDTH-2:0], 1'b0};
      end
    end else begin : g_single
      always_comb begin
        word_d = word_q;
        if (take)          word_d = din;
        else if (shift_en) word_d = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign msb = word_q[WIDTH-1];

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (word_q == $past(din)));

  generate
    if (WIDTH > 1) begin : g_shift_chk
      // R3
      msb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !take) |=> (word_q[WIDTH-1] == $past(word_q[WIDTH-2])));
    end
  endgenerate

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !shift_en) |=> $stable(word_q));
endmodule

// File: rtl/oc_tx_top.sv
module oc_tx_top
  import oc_tx_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] par_data,
  output logic             busy,
  output logic             tx_line
);
  logic active, take, shift_en, cur_bit, drive_en;

  oc_tx_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .active   (active),
    .take     (take),
    .shift_en (shift_en)
  );

  oc_tx_sreg #(.WIDTH(WIDTH)) u_sreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .shift_en (shift_en),
    .din      (par_data),
    .msb      (cur_bit)
  );

  // Drive enable plus a fixed pull level, resolved to 0 or Z here.
  assign drive_en = active & cur_bit;
  assign busy     = active;
  assign tx_line  = drive_en ? LINE_PULL : 1'bz;

  // R6
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !drive_en);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (!busy && !drive_en));
endmodule

// File: tb/tb_oc_tx_top.sv
module tb_oc_tx_top;
  localparam int unsigned WIDTH = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 6;
  // Each entry holds {word to send, expected line levels per bit, MSB first}.
  localparam logic [15:0] VEC [NVEC] = '{
    16'hA5_5A, 16'h00_FF, 16'hFF_00, 16'h81_7E, 16'h3C_C3, 16'h01_FE
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [WIDTH-1:0] par_data = '0;
  logic busy;
  wire  bus_line;
  int   errs = 0;
  int   checks = 0;
  bit   done = 1'b0;

  pullup (bus_line);

  oc_tx_top #(.WIDTH(WIDTH)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .par_data (par_data),
    .busy     (busy),
    .tx_line  (bus_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Sends a word and checks every bit period. When lead is set, the data
  // is placed one clock ahead of the strobe. A strobe carrying 'other'
  // is injected while bit index inj_at is on the line (-1 for none).
  // After the capture, par_data is changed to 'nxt'.
  task automatic xfer(input logic [WIDTH-1:0] word, input logic [WIDTH-1:0] exp_line,
                      input int inj_at, input logic [WIDTH-1:0] other,
                      input logic [WIDTH-1:0] nxt, input bit lead);
    par_data = word;
    if (lead) @(negedge clk);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    par_data = nxt;                                    // R8
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (i != WIDTH - 1) @(negedge clk);
      load = 1'b0;
      chk("R5 busy", busy, 1'b1);
      chk("R3/R4 bit", bus_line, exp_line[i]);
      if (i == inj_at) begin
        load = 1'b1;                                   // R7
        par_data = other;
      end
    end
    @(negedge clk);
    load = 1'b0;
    par_data = nxt;
    chk("R5 end", busy, 1'b0);
    chk("R6 release", bus_line, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #(CLK_PERIOD * 2 + CLK_PERIOD/4);
    chk("R1 busy", busy, 1'b0);
    chk("R1 line", bus_line, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 1'b0);
    chk("R1 line", bus_line, 1'b1);

    // R6: idle with data present and no strobe
    par_data = 8'hFF;
    repeat (2) @(negedge clk);
    chk("R6 idle", bus_line, 1'b1);

    // R2 R3 R4 R5: table of words
    for (int v = 0; v < NVEC; v++) begin
      xfer(VEC[v][15:8], VEC[v][7:0], -1, '0, ~VEC[v][15:8], 1'b1);
    end

    // R7: strobe mid-word, and again in the last bit period
    xfer(8'hC6, 8'h39, 4, 8'hFF, 8'h00, 1'b1);
    xfer(8'h96, 8'h69, 0, 8'hFF, 8'h00, 1'b1);
    @(negedge clk);
    chk("R7 no restart", busy, 1'b0);

    // R10: next word loaded the period busy is low again
    xfer(8'hB1, 8'h4E, -1, '0, 8'h5D, 1'b1);
    xfer(8'h5D, 8'hA2, -1, '0, 8'h00, 1'b0);

    // R9: asynchronous reset mid-transfer
    par_data = 8'hFF;
    @(negedge clk);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 pre", bus_line, 1'b0);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk("R9 busy", busy, 1'b0);
    chk("R9 line", bus_line, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 stays idle", busy, 1'b0);
    xfer(8'h2B, 8'hD4, -1, '0, 8'h00, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule